// File: doc/BRIEF.md
# Composite Sync Width Classifier

This block watches a one-bit composite-sync signal that is low whenever the video level falls below the black threshold. It times every low interval with the sample clock and sorts each one into one of three classes. An interval that is too short is noise. A medium one is a line sync. A long one is a frame sync. From the accepted syncs it keeps a line number that restarts at every frame sync. It also gives a one-cycle strobe when that number reaches a programmable insert line, where overlay text would begin.

After reset the block is in search mode. In this mode it ignores line syncs and waits for a frame sync. Once a frame sync is found it tracks the video. In tracking mode a pulse counts only if its falling edge lands inside a window around the expected line period, measured from the previous accepted falling edge. The lock flag rises with the first line sync accepted in this way. It falls, and the block returns to search mode, when no sync comes before a timeout. A stretched frame-seen output lights an indicator, so that the comparator threshold can be adjusted by hand.

All durations are parameters given in sample clocks. The defaults assume a 27 MHz sample clock and standard 64 µs lines:
- line sync near 4.7 µs,
- noise below 2 µs,
- frame sync above 10 µs,
- window of ±1 µs,
- timeout of 70 µs.

Top module: `csync_classifier`

## Requirements
- R1: While reset is held low, and just after it is released, `locked`, `line_pulse`, `frame_pulse`, `insert_stb` and `frame_seen` are 0 and `line_num` is 0.
- R2: A low interval of fewer than MIN_PULSE sample clocks is ignored. It produces no pulse and does not move the reference point for the next window.
- R3: A low interval of MIN_PULSE to FRAME_MIN-1 clocks is a line sync. One of FRAME_MIN clocks or more is a frame sync. Each accepted sync gives a one-cycle `line_pulse` or `frame_pulse`, and the two never occur together.
- R4: In search mode, line syncs are ignored and a frame sync of any timing is accepted, which starts tracking.
- R5: In tracking mode, a sync is accepted only when its falling edge comes LINE_NOM-WIN to LINE_NOM+WIN clocks after the falling edge of the previous accepted sync.
- R6: An accepted frame sync sets `line_num` to 0, and each accepted line sync increments it by one.
- R7: `insert_stb` pulses for one cycle, with `line_num` equal to `insert_line`, on the accepted line sync that brings `line_num` to `insert_line`. An `insert_line` of 0 never strobes.
- R8: `locked` rises together with the first accepted line sync after a frame sync. When TIMEOUT clocks pass after the last accepted falling edge with the input high, `locked` falls and the block returns to search mode.
- R9: `frame_seen` stays high for FLASH_LEN cycles after any interval classified as frame sync, whether or not the mode or the window accepted it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_n | input | 1 | Digitized composite sync, low below black level |
| insert_line | input | LINE_W | Line number at which the insert strobe fires |
| line_pulse | output | 1 | One-cycle strobe for an accepted line sync |
| frame_pulse | output | 1 | One-cycle strobe for an accepted frame sync |
| line_num | output | LINE_W | Lines since the last accepted frame sync |
| insert_stb | output | 1 | One-cycle strobe when the insert line is reached |
| frame_seen | output | 1 | Stretched frame-sync indicator for threshold setup |
| locked | output | 1 | Sync arriving at the expected times |

## Verification
Two situations are hard to reach from the pins. The first is a sync whose falling edge sits just inside or just outside the window edge while the block is tracking. The bench reaches it by a frame sync followed by a line sync at each spacing from well below to well above LINE_NOM, one fresh reset per spacing. The second is proving that a noise glitch does not restart the timing. For that, a glitch is placed inside a line, and the next real sync is positioned so that it is in the window only when measured from the earlier real edge. Pulse widths are swept one clock at a time across both classification thresholds.

// File: rtl/csync_classifier.sv
module csync_classifier #(
  parameter int MIN_PULSE = 54,
  parameter int FRAME_MIN = 270,
  parameter int LINE_NOM  = 1728,
  parameter int WIN       = 27,
  parameter int TIMEOUT   = 1890,
  parameter int FLASH_LEN = 2700000,
  parameter int LINE_W    = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_n,
  input  logic [LINE_W-1:0] insert_line,
  output logic              line_pulse,
  output logic              frame_pulse,
  output logic [LINE_W-1:0] line_num,
  output logic              insert_stb,
  output logic              frame_seen,
  output logic              locked
);
  localparam int CW = $clog2(TIMEOUT + 2);
  localparam int FW = $clog2(FLASH_LEN + 1);
  localparam logic [CW-1:0] K_MIN = CW'(MIN_PULSE);
  localparam logic [CW-1:0] K_FRM = CW'(FRAME_MIN);
  localparam logic [CW-1:0] K_LO  = CW'(LINE_NOM - WIN);
  localparam logic [CW-1:0] K_HI  = CW'(LINE_NOM + WIN);
  localparam logic [CW-1:0] K_TO  = CW'(TIMEOUT);
  localparam logic [FW-1:0] K_FL  = FW'(FLASH_LEN);

  logic          in_q, in_d, track;
  logic [CW-1:0] wcnt, pcnt, fall_at;
  logic [FW-1:0] flash;

  wire fall       = in_d & ~in_q;
  wire rise       = ~in_d & in_q;
  wire is_frame   = rise && wcnt >= K_FRM;
  wire is_line    = rise && wcnt >= K_MIN && wcnt < K_FRM;
  wire in_win     = fall_at >= K_LO && fall_at <= K_HI;
  wire take_frame = is_frame && (!track || in_win);
  wire take_line  = is_line && track && in_win;
  wire take       = take_frame | take_line;
  wire expire     = track && in_q && pcnt >= K_TO && !take;

  assign frame_seen = flash != '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_q <= 1'b1;
      in_d <= 1'b1;
      wcnt <= '0;
      fall_at <= '0;
    end else begin
      in_q <= sync_n;
      in_d <= in_q;
      if (fall) fall_at <= pcnt;
      if (fall) wcnt <= CW'(1);
      else if (!in_q && wcnt != K_TO) wcnt <= wcnt + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pcnt <= K_TO;
    else if (take) pcnt <= (wcnt >= K_TO) ? K_TO : wcnt + CW'(1);
    else if (pcnt != K_TO) pcnt <= pcnt + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      track  <= 1'b0;
      locked <= 1'b0;
    end else begin
      if (take_frame) track <= 1'b1;
      else if (expire) track <= 1'b0;
      if (expire) locked <= 1'b0;
      else if (take_line) locked <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_num    <= '0;
      line_pulse  <= 1'b0;
      frame_pulse <= 1'b0;
      insert_stb  <= 1'b0;
    end else begin
      line_pulse  <= take_line;
      frame_pulse <= take_frame;
      insert_stb  <= take_line && (line_num + LINE_W'(1)) == insert_line && insert_line != '0;
      if (take_frame) line_num <= '0;
      else if (take_line) line_num <= line_num + LINE_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flash <= '0;
    else if (is_frame) flash <= K_FL;
    else if (flash != '0) flash <= flash - FW'(1);
  end

  p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_pulse && frame_pulse));
  p_search_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!track && !locked) |=> !line_pulse);
  p_frame_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pulse |-> line_num == '0);
  p_ins_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    insert_stb |-> (line_num == insert_line && line_pulse));
  p_lock_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> line_pulse);
  p_lock_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> track);
  p_flash_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pulse |-> frame_seen);
endmodule

// File: tb/test_csync_classifier.sv
module test_csync_classifier;
  localparam int LW = 5;
  logic clk = 1'b0, rst_n = 1'b0, sync_n = 1'b1;
  logic [LW-1:0] insert_line = '0;
  logic line_pulse, frame_pulse, insert_stb, frame_seen, locked;
  logic [LW-1:0] line_num;
  int n_chk = 0, n_bad = 0;
  int lp = 0, fp = 0, ins = 0, ins_line = -1;

  always #4 clk = ~clk;

  csync_classifier #(.MIN_PULSE(3), .FRAME_MIN(10), .LINE_NOM(40), .WIN(2),
    .TIMEOUT(50), .FLASH_LEN(20), .LINE_W(LW)) i_csync_classifier (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .insert_line(insert_line),
    .line_pulse(line_pulse), .frame_pulse(frame_pulse), .line_num(line_num),
    .insert_stb(insert_stb), .frame_seen(frame_seen), .locked(locked));

  always @(negedge clk) begin
    if (rst_n) begin
      if (line_pulse) lp++;
      if (frame_pulse) fp++;
      if (insert_stb) begin ins++; ins_line = int'(line_num); end
    end
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic restart();
    rst_n = 1'b0; sync_n = 1'b1;
    tick(3);
    lp = 0; fp = 0; ins = 0; ins_line = -1;
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic pulse(int lo, int total);
    sync_n = 1'b0; tick(lo);
    sync_n = 1'b1; tick(total - lo);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick(2);
    chk("R1 locked in reset", int'(locked), 0);
    chk("R1 seen in reset", int'(frame_seen), 0);
    restart();
    chk("R1 line_num", int'(line_num), 0);
    chk("R1 locked", int'(locked), 0);
    chk("R1 pulses", int'({line_pulse, frame_pulse, insert_stb, frame_seen}), 0);

    for (int k = 0; k < 3; k++) pulse(5, 40);
    chk("R4 search ignores lines", lp, 0);
    chk("R4 no lock in search", int'(locked), 0);

    // R9 flash in search, then expiry
    restart();
    sync_n = 1'b0; tick(12); sync_n = 1'b1; tick(3);
    chk("R9 seen after frame", int'(frame_seen), 1);
    chk("R4 frame accepted in search", fp, 1);
    tick(30);
    chk("R9 seen expired", int'(frame_seen), 0);

    // R3 width sweep across both thresholds
    for (int w = 1; w <= 14; w++) begin
      restart();
      pulse(12, 40); pulse(5, 40); pulse(w, 40);
      if (w < 3) begin
        chk("R2 short ignored (line)", lp, 1);
        chk("R2 short ignored (frame)", fp, 1);
      end else if (w < 10) begin
        chk("R3 line class", lp, 2);
        chk("R6 line count", int'(line_num), 2);
      end else begin
        chk("R3 frame class", fp, 2);
        chk("R6 frame clears count", int'(line_num), 0);
      end
    end

    // R2 glitch does not restart timing
    restart();
    pulse(12, 40); pulse(5, 15); pulse(2, 25); pulse(5, 40);
    chk("R2 glitch keeps timing", lp, 2);
    chk("R6 count after glitch", int'(line_num), 2);

    // R5 window sweep
    for (int p = 34; p <= 46; p++) begin
      restart();
      pulse(12, p); pulse(5, 40);
      chk("R5 window accept", lp, (p >= 38 && p <= 42) ? 1 : 0);
      chk("R8 lock follows accept", int'(locked), (p >= 38 && p <= 42) ? 1 : 0);
    end

    // R7 insert line sweep
    for (int il = 0; il <= 6; il++) begin
      restart();
      insert_line = LW'(il);
      pulse(12, 40);
      for (int k = 0; k < 6; k++) pulse(5, 40);
      chk("R7 strobe count", ins, (il == 0) ? 0 : 1);
      if (il != 0) chk("R7 strobe line", ins_line, il);
    end
    insert_line = '0;

    // R9 frame flagged even when window rejects it
    restart();
    pulse(12, 40); pulse(5, 20);
    sync_n = 1'b0; tick(12); sync_n = 1'b1; tick(3);
    chk("R9 seen on rejected frame", int'(frame_seen), 1);
    chk("R5 off-window frame rejected", fp, 1);

    // R8 timeout
    restart();
    pulse(12, 40); pulse(5, 40);
    tick(5);
    chk("R8 still locked before timeout", int'(locked), 1);
    tick(10);
    chk("R8 lock lost after timeout", int'(locked), 0);
    pulse(5, 40);
    chk("R8 back in search", lp, 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule